// File: doc/BRIEF.md
# Command Ring Write Controller

This block is the host-side producer for a circular ring of 32-bit command words. A command arrives over a valid/ready handshake. The block checks it against the ring's hardware read pointer. When there is room, it emits one ring write strobe carrying the slot index and the word, and it advances its own write pointer. Commands are written one slot ahead of the pointer: the pointer is incremented first, modulo the ring depth, and the word lands at the new value. A command is refused with a retry code when the incremented pointer would land on the read pointer. It is refused with a powered-down code when the read pointer reads as all ones.

Before commands are taken, an initialisation sequence runs. It clears the write pointer. It then performs a two-phase handshake on the hardware read pointer: it writes the pointer's reset bit, waits until the hardware echoes that bit, writes zero, and waits until the pointer reads zero. Each wait is bounded by a poll limit, and a sticky flag records any expired wait. After the handshake the ring is marked running.

Every accepted command is attributed to a target. The target is the top nibble of the word, and out-of-range values fold to target 0. The block keeps a saturating outstanding-command counter and a last-command register for each target. A response dispatcher decrements the counters through a separate port.

States: STOPPED (idle, not running), RP_ASSERT (write the reset bit), RP_WAIT_SET (poll for the echoed bit), RP_RELEASE (write zero), RP_WAIT_ZERO (poll for zero), RUN (accepting), REJECT (one cycle after a refusal). Transitions: STOPPED→RP_ASSERT on init request. RP_ASSERT→RP_WAIT_SET always. RP_WAIT_SET→RP_RELEASE when bit 15 of the read pointer is set or the poll limit expires. RP_RELEASE→RP_WAIT_ZERO always. RP_WAIT_ZERO→RUN when the pointer is zero or the poll limit expires. RUN→REJECT on a refused command. REJECT→RUN after one cycle. RUN or REJECT→STOPPED on stop request.

Top module: `cmd_ring_writer`

## Requirements
- R1: After reset the block is in STOPPED: cmd_ready, run_o, ring_we and rp_wr are 0, wp_out is 0, err_code is 0 and every outstanding counter is 0.
- R2: An init request in STOPPED clears wp_out to 0. In the next cycle it drives rp_wr with rp_wdata = 16'h8000 (bit 15 is the reset bit). Once bit 15 of hw_rp reads set, it drives rp_wr with rp_wdata = 0. Once hw_rp reads 0, cmd_ready rises. With prompt echoes the two write strobes are 2 cycles apart.
- R3: Each of the two waits lasts at most POLL_LIMIT (default 1000) cycles. On expiry rst_timeout is set, stays set until the next init request, and the sequence proceeds. An unanswered first wait puts the two write strobes POLL_LIMIT+1 cycles apart.
- R4: cmd_ready is high only in RUN. An accepted command is written in the cycle after the handshake: ring_we=1, ring_idx = (wp_out+1) mod RING_DEPTH, ring_wdata = the word. wp_out takes the same new value.
- R5: The write pointer wraps from RING_DEPTH-1 to 0.
- R6: When (wp_out+1) mod RING_DEPTH equals hw_rp, the command is refused with err_code = 1 (full). There is no ring write and wp_out is unchanged.
- R7: When hw_rp is 16'hFFFF, the command is refused with err_code = 2 (powered down). This takes precedence over the full check, and there is no ring write.
- R8: The target is cmd_data[31:28]. A value of MAX_TGT (default 15) or above is replaced by 0. Each accepted command increments that target's 8-bit counter in out_cnt (bits [8t+7:8t]).
- R9: An outstanding counter saturates at 255.
- R10: A pulse on rsp_dec_valid decrements the counter of rsp_dec_tgt, and the counter never goes below 0. An increment and a decrement of the same target in one cycle leave it unchanged. A decrement target of MAX_TGT or above is ignored.
- R11: Each accepted command is stored as its target's last command in last_cmd (bits [32t+31:32t]).
- R12: A refusal holds cmd_ready low for exactly one cycle. err_code is non-zero for exactly that cycle.
- R13: A stop request in RUN or REJECT returns to STOPPED. While stopped, a valid command is neither accepted nor written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Start the initialisation sequence (in STOPPED) |
| stop_req | input | 1 | Clear the run state |
| cmd_valid | input | 1 | Command word present |
| cmd_data | input | 32 | Command word, target in [31:28] |
| cmd_ready | output | 1 | Command handshake ready |
| hw_rp | input | 16 | Hardware read pointer value as read |
| rp_wr | output | 1 | Write strobe to the hardware read pointer |
| rp_wdata | output | 16 | Value written to the hardware read pointer |
| ring_we | output | 1 | Ring slot write strobe |
| ring_idx | output | 8 | Ring slot index |
| ring_wdata | output | 32 | Ring slot data |
| wp_out | output | 8 | Current write pointer |
| run_o | output | 1 | Ring running |
| err_code | output | 2 | 0 none, 1 full, 2 powered down (one-cycle pulse) |
| rst_timeout | output | 1 | Sticky read-pointer handshake timeout |
| rsp_dec_valid | input | 1 | Dispatcher decrement request |
| rsp_dec_tgt | input | 4 | Target to decrement |
| out_cnt | output | 120 | Outstanding counters, 8 bits per target |
| last_cmd | output | 480 | Last command word, 32 bits per target |

## Verification
The bench targets the full boundary, where the pre-incremented pointer meets the read pointer. A design that compares the current pointer instead would overwrite an unread slot or refuse one slot too early. It also checks that the all-ones read pointer wins over the full test, and it steps the pointer through the wrap from 255 to 0. An off-by-one there would write slot 256's alias or stall. Further tests leave the reset-bit echo unanswered to measure the exact poll bound. They drive counters into saturation and below zero, and they collide an increment with a decrement on the same target. A wrapping counter or a lost decrement would show up directly in out_cnt.

// File: rtl/cring_pkg.sv
package cring_pkg;
    typedef enum logic [2:0] {
        ST_STOPPED,
        ST_RP_ASSERT,
        ST_RP_WAIT_SET,
        ST_RP_RELEASE,
        ST_RP_WAIT_ZERO,
        ST_RUN,
        ST_REJECT
    } cring_state_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_FULL = 2'd1,
        ERR_PWR  = 2'd2
    } cring_err_e;

    localparam logic [15:0] RP_RESET_BIT = 16'h8000;
    localparam logic [15:0] RP_DEAD     = 16'hFFFF;
endpackage

// File: rtl/cring_poll_timer.sv
module cring_poll_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LAST);
endmodule

// File: rtl/cring_tgt_decode.sv
module cring_tgt_decode #(
    parameter int MAX_TGT = 15
) (
    input  logic [3:0] nibble,
    output logic [3:0] tgt,
    output logic       in_range
);
    always_comb begin
        in_range = (32'(nibble) < MAX_TGT);
        tgt      = in_range ? nibble : 4'd0;
    end
endmodule

// File: rtl/cring_tgt_counters.sv
module cring_tgt_counters #(
    parameter int MAX_TGT = 15,
    parameter int CNT_W   = 8,
    parameter int WORD_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      inc_en,
    input  logic [3:0]                inc_tgt,
    input  logic [WORD_W-1:0]         inc_word,
    input  logic                      dec_en,
    input  logic [3:0]                dec_tgt,
    output logic [MAX_TGT*CNT_W-1:0]  cnt_flat,
    output logic [MAX_TGT*WORD_W-1:0] last_flat
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar t = 0; t < MAX_TGT; t++) begin : g_tgt
        logic [CNT_W-1:0]  cnt_q;
        logic [WORD_W-1:0] last_q;
        logic              hit_inc;
        logic              hit_dec;

        assign hit_inc = inc_en && (32'(inc_tgt) == t);
        assign hit_dec = dec_en && (32'(dec_tgt) == t);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q  <= '0;
                last_q <= '0;
            end else begin
                if (hit_inc) begin
                    last_q <= inc_word;
                end
                unique case ({hit_inc, hit_dec})
                    2'b10: if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                    2'b01: if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
                    default: cnt_q <= cnt_q;
                endcase
            end
        end

        assign cnt_flat[t*CNT_W +: CNT_W]    = cnt_q;
        assign last_flat[t*WORD_W +: WORD_W] = last_q;
    end
endmodule

// File: rtl/cmd_ring_writer.sv
module cmd_ring_writer
    import cring_pkg::*;
#(
    parameter int RING_DEPTH = 256,
    parameter int MAX_TGT    = 15,
    parameter int POLL_LIMIT = 1000,
    parameter int CNT_W      = 8,
    localparam int IDX_W     = $clog2(RING_DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     init_req,
    input  logic                     stop_req,
    input  logic                     cmd_valid,
    input  logic [31:0]              cmd_data,
    output logic                     cmd_ready,
    input  logic [15:0]              hw_rp,
    output logic                     rp_wr,
    output logic [15:0]              rp_wdata,
    output logic                     ring_we,
    output logic [IDX_W-1:0]         ring_idx,
    output logic [31:0]              ring_wdata,
    output logic [IDX_W-1:0]         wp_out,
    output logic                     run_o,
    output logic [1:0]               err_code,
    output logic                     rst_timeout,
    input  logic                     rsp_dec_valid,
    input  logic [3:0]               rsp_dec_tgt,
    output logic [MAX_TGT*CNT_W-1:0] out_cnt,
    output logic [MAX_TGT*32-1:0]    last_cmd
);
    localparam logic [IDX_W-1:0] WP_LAST = IDX_W'(RING_DEPTH - 1);

    cring_state_e state_q, state_d;

    logic [IDX_W-1:0] wp_q;
    logic [IDX_W-1:0] wp_next;
    logic             poll_clr, poll_en, poll_exp;
    logic             take;
    logic             is_dead, is_full;
    logic             accept, refuse;
    logic [3:0]       inc_tgt, dec_tgt;
    logic             inc_ok, dec_ok;

    // ---------------- helpers ----------------
    assign wp_next = (wp_q == WP_LAST) ? '0 : wp_q + 1'b1;
    assign take    = cmd_valid && cmd_ready;
    assign is_dead = (hw_rp == RP_DEAD);
    assign is_full = (hw_rp == 16'(wp_next));
    assign accept  = take && !is_dead && !is_full;
    assign refuse  = take && (is_dead || is_full);

    assign poll_clr = (state_q == ST_RP_ASSERT) || (state_q == ST_RP_RELEASE);
    assign poll_en  = (state_q == ST_RP_WAIT_SET) || (state_q == ST_RP_WAIT_ZERO);

    cring_poll_timer #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (poll_clr),
        .en      (poll_en),
        .expired (poll_exp)
    );

    cring_tgt_decode #(.MAX_TGT(MAX_TGT)) u_inc_dec (
        .nibble   (cmd_data[31:28]),
        .tgt      (inc_tgt),
        .in_range (inc_ok)
    );

    cring_tgt_decode #(.MAX_TGT(MAX_TGT)) u_rsp_dec (
        .nibble   (rsp_dec_tgt),
        .tgt      (dec_tgt),
        .in_range (dec_ok)
    );

    cring_tgt_counters #(
        .MAX_TGT (MAX_TGT),
        .CNT_W   (CNT_W),
        .WORD_W  (32)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_en    (accept),
        .inc_tgt   (inc_tgt),
        .inc_word  (cmd_data),
        .dec_en    (rsp_dec_valid && dec_ok),
        .dec_tgt   (dec_tgt),
        .cnt_flat  (out_cnt),
        .last_flat (last_cmd)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED:      if (init_req) state_d = ST_RP_ASSERT;
            ST_RP_ASSERT:    state_d = ST_RP_WAIT_SET;
            ST_RP_WAIT_SET:  if (hw_rp[15] || poll_exp) state_d = ST_RP_RELEASE;
            ST_RP_RELEASE:   state_d = ST_RP_WAIT_ZERO;
            ST_RP_WAIT_ZERO: if (hw_rp == '0 || poll_exp) state_d = ST_RUN;
            ST_RUN: begin
                if (stop_req)    state_d = ST_STOPPED;
                else if (refuse) state_d = ST_REJECT;
            end
            ST_REJECT: state_d = stop_req ? ST_STOPPED : ST_RUN;
            default:   state_d = ST_STOPPED;
        endcase
    end

    // ---------------- Moore outputs ----------------
    assign cmd_ready = (state_q == ST_RUN) && !stop_req;
    assign run_o     = (state_q == ST_RUN) || (state_q == ST_REJECT);
    assign rp_wr     = (state_q == ST_RP_ASSERT) || (state_q == ST_RP_RELEASE);
    assign rp_wdata  = (state_q == ST_RP_ASSERT) ? RP_RESET_BIT : 16'h0000;

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q        <= '0;
            ring_we     <= 1'b0;
            ring_idx    <= '0;
            ring_wdata  <= '0;
            err_code    <= ERR_NONE;
            rst_timeout <= 1'b0;
        end else begin
            ring_we  <= 1'b0;
            err_code <= ERR_NONE;
            unique case (state_q)
                ST_STOPPED: begin
                    if (init_req) begin
                        wp_q        <= '0;
                        rst_timeout <= 1'b0;
                    end
                end
                ST_RP_WAIT_SET: begin
                    if (!hw_rp[15] && poll_exp) rst_timeout <= 1'b1;
                end
                ST_RP_WAIT_ZERO: begin
                    if (hw_rp != '0 && poll_exp) rst_timeout <= 1'b1;
                end
                ST_RUN: begin
                    if (accept) begin
                        wp_q       <= wp_next;
                        ring_we    <= 1'b1;
                        ring_idx   <= wp_next;
                        ring_wdata <= cmd_data;
                    end else if (refuse) begin
                        err_code <= is_dead ? ERR_PWR : ERR_FULL;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign wp_out = wp_q;

    logic unused_ok;
    assign unused_ok = inc_ok;
endmodule

// File: rtl/cring_chk.sv
module cring_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             ring_we,
    input logic [IDX_W-1:0] ring_idx,
    input logic [IDX_W-1:0] wp_out,
    input logic [1:0]       err_code,
    input logic             rp_wr,
    input logic             run_o
);
    // R4
    ring_idx_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_we |-> ring_idx == IDX_W'($past(wp_out) + 1'b1));

    // R4
    write_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_we |-> $past(cmd_valid && cmd_ready));

    // R6
    full_keeps_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'd0) |-> (!ring_we && wp_out == $past(wp_out)));

    // R12
    reject_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'd0) |-> !cmd_ready);

    // R12
    err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'd0) |=> (err_code == 2'd0));

    // R2
    no_ptr_write_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rp_wr |-> !run_o);
endmodule

bind cmd_ring_writer cring_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .ring_we   (ring_we),
    .ring_idx  (ring_idx),
    .wp_out    (wp_out),
    .err_code  (err_code),
    .rp_wr     (rp_wr),
    .run_o     (run_o)
);

// File: tb/cmd_ring_writer_tb_top.sv
module cmd_ring_writer_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init_req = 1'b0, stop_req = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [31:0]  cmd_data = '0;
    logic         cmd_ready;
    logic [15:0]  hw_rp = '0;
    logic         rp_wr;
    logic [15:0]  rp_wdata;
    logic         ring_we;
    logic [7:0]   ring_idx;
    logic [31:0]  ring_wdata;
    logic [7:0]   wp_out;
    logic         run_o;
    logic [1:0]   err_code;
    logic         rst_timeout;
    logic         rsp_dec_valid = 1'b0;
    logic [3:0]   rsp_dec_tgt = '0;
    logic [119:0] out_cnt;
    logic [479:0] last_cmd;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    cmd_ring_writer dut_i (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .stop_req(stop_req),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .hw_rp(hw_rp), .rp_wr(rp_wr), .rp_wdata(rp_wdata),
        .ring_we(ring_we), .ring_idx(ring_idx), .ring_wdata(ring_wdata),
        .wp_out(wp_out), .run_o(run_o), .err_code(err_code),
        .rst_timeout(rst_timeout), .rsp_dec_valid(rsp_dec_valid),
        .rsp_dec_tgt(rsp_dec_tgt), .out_cnt(out_cnt), .last_cmd(last_cmd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] cnt_of(input int t);
        return out_cnt[t*8 +: 8];
    endfunction

    // one handshake; returns at the negedge after the capturing edge
    task automatic issue(input logic [31:0] w, input logic [15:0] rp);
        cmd_data  = w;
        hw_rp     = rp;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_init(input bit respond, output int gap);
        init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
        chk("R2 reset-bit write", {15'd0, rp_wr, rp_wdata}, {15'd0, 1'b1, 16'h8000});
        chk("R2 wp cleared", 32'(wp_out), 32'd0);
        if (respond) hw_rp = 16'h8000;
        gap = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            gap++;
            if (rp_wr) break;
        end
        chk("R2 zero write", {15'd0, rp_wr, rp_wdata}, {15'd0, 1'b1, 16'h0000});
        hw_rp = 16'h0000;
        for (int i = 0; i < 10; i++) begin
            if (cmd_ready) break;
            @(negedge clk);
        end
        chk("R2 ready after handshake", 32'(cmd_ready), 32'd1);
    endtask

    // cmd, rp, expected err, expected idx
    localparam logic [57:0] VEC [7] = '{
        {32'h1000_0001, 16'h0000, 2'd0, 8'd1},
        {32'h2000_0002, 16'h0000, 2'd0, 8'd2},
        {32'hF000_0003, 16'h0000, 2'd0, 8'd3},
        {32'h1000_0004, 16'h0004, 2'd1, 8'd0},
        {32'h3000_0005, 16'hFFFF, 2'd2, 8'd0},
        {32'h3000_0006, 16'h0005, 2'd0, 8'd4},
        {32'h2000_0007, 16'h0000, 2'd0, 8'd5}
    };

    initial begin
        int gap;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(cmd_ready), 32'd0);
        chk("R1 run", 32'(run_o), 32'd0);
        chk("R1 strobes", {30'd0, ring_we, rp_wr}, 32'd0);
        chk("R1 wp/err", {22'd0, wp_out, err_code}, 32'd0);
        chk("R1 counters", 32'(|out_cnt), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 stopped: commands ignored
        issue(32'h1111_1111, 16'h0000);
        chk("R13 no write while stopped", {23'd0, ring_we, wp_out}, 32'd0);

        do_init(1'b1, gap);
        chk("R2 echo gap", 32'(gap), 32'd2);
        chk("R3 no timeout", 32'(rst_timeout), 32'd0);
        chk("R2 run", 32'(run_o), 32'd1);

        foreach (VEC[k]) begin
            logic [7:0] wp_before;
            wp_before = wp_out;
            issue(VEC[k][57:26], VEC[k][25:10]);
            if (VEC[k][9:8] != 2'd0) begin
                chk($sformatf("R6/R7 err vec%0d", k), 32'(err_code), 32'(VEC[k][9:8]));
                chk("R6 no write", 32'(ring_we), 32'd0);
                chk("R6 wp held", 32'(wp_out), 32'(wp_before));
                chk("R12 ready low", 32'(cmd_ready), 32'd0);
                hw_rp = 16'h0000;
                @(negedge clk);
                chk("R12 err cleared", 32'(err_code), 32'd0);
                chk("R12 ready back", 32'(cmd_ready), 32'd1);
            end else begin
                chk($sformatf("R4 write vec%0d", k), {23'd0, ring_we, ring_idx}, {23'd0, 1'b1, VEC[k][7:0]});
                chk("R4 data", ring_wdata, VEC[k][57:26]);
                chk("R4 wp", 32'(wp_out), 32'(VEC[k][7:0]));
            end
        end
        // R8 counts, R11 last words
        chk("R8 tgt0 (folded)", 32'(cnt_of(0)), 32'd1);
        chk("R8 tgt1", 32'(cnt_of(1)), 32'd1);
        chk("R8 tgt2", 32'(cnt_of(2)), 32'd2);
        chk("R8 tgt3", 32'(cnt_of(3)), 32'd1);
        chk("R11 last tgt2", last_cmd[2*32 +: 32], 32'h2000_0007);
        chk("R11 last tgt0", last_cmd[0 +: 32], 32'hF000_0003);

        // R5 wrap: wp 5 -> 255 -> 0 with rp=1
        for (int i = 0; i < 250; i++) issue(32'h4000_0000 + 32'(i), 16'h0001);
        chk("R5 at top", 32'(wp_out), 32'd255);
        issue(32'h4AAA_0000, 16'h0001);
        chk("R5 wrapped idx", {23'd0, ring_we, ring_idx}, {23'd0, 1'b1, 8'd0});
        issue(32'h4BBB_0000, 16'h0001);
        chk("R6 full at wrap", 32'(err_code), 32'd1);
        @(negedge clk);
        for (int i = 0; i < 10; i++) issue(32'h4000_1000, 16'h0080);
        chk("R9 saturated", 32'(cnt_of(4)), 32'd255);

        // R10 decrement, floor, collision
        rsp_dec_tgt = 4'd2;
        rsp_dec_valid = 1'b1;
        repeat (3) @(negedge clk);
        rsp_dec_valid = 1'b0;
        chk("R10 floor at 0", 32'(cnt_of(2)), 32'd0);
        rsp_dec_tgt = 4'd3;
        rsp_dec_valid = 1'b1;
        issue(32'h3000_0009, 16'h0080);
        rsp_dec_valid = 1'b0;
        chk("R10 collision unchanged", 32'(cnt_of(3)), 32'd1);
        rsp_dec_tgt = 4'd15;
        rsp_dec_valid = 1'b1;
        @(negedge clk);
        rsp_dec_valid = 1'b0;
        chk("R10 out-of-range ignored", 32'(cnt_of(0)), 32'd1);

        // R13 stop
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk("R13 stopped", {30'd0, run_o, cmd_ready}, 32'd0);
        begin
            logic [7:0] w0;
            w0 = wp_out;
            issue(32'h5000_0000, 16'h0080);
            chk("R13 ignored cmd", {23'd0, ring_we, wp_out}, {23'd0, 1'b0, w0});
        end

        // R3 timeout on first wait
        hw_rp = 16'h0000;
        do_init(1'b0, gap);
        chk("R3 poll bound", 32'(gap), 32'd1001);
        chk("R3 timeout flag", 32'(rst_timeout), 32'd1);
        chk("R2 wp zero after init", 32'(wp_out), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule